// File: doc/BRIEF.md
# Linked Directory Node Search Engine

This block finds one file by name in a directory held on block storage. The directory is a chain of directory nodes. Each node starts on its own 512-byte logical block and names the node after it; a next pointer of zero ends the chain. After a start pulse the engine loads the root node number into its single current-node register. It then asks a byte-streaming storage reader for the block at partition base plus node number. The reader returns the whole block one byte at a time.

The engine holds no copy of the block. Each byte is decoded the cycle it arrives. The flags, the next pointer and the child pointer are captured. The name length and the name bytes are compared against a fixed name held in a small internal ROM (default `bootimg`, 7 characters). When the last byte of the block has arrived, the engine makes one of three choices:
- If the entry is a file whose name matches, it reports the child pointer as the first data node of the file.
- If there is no match and the next pointer is nonzero, it moves on to the next node.
- If there is no match and the next pointer is zero, it reports an error.

Top module: `dirnode_seeker`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `rd_req_o` are low, and `data_node_o` is 0.
- R2: A `start_i` pulse while idle loads `root_node_i` and captures `part_base_i`. It raises `busy_o` and issues a one-cycle `rd_req_o` with `rd_addr_o` equal to the captured base plus the node number.
- R3: Node byte layout, counting from 0 within the block:
  - byte 0 is flags;
  - bytes 1..4 are the next pointer;
  - bytes 5..8 are the child pointer;
  - bytes 9..12 are not used;
  - byte 13 is the name length;
  - the name starts at byte 14.
  Pointers are little-endian, least significant byte first.
- R4: A name matches only when the length byte equals 7 and bytes 14..20 equal the ASCII characters `bootimg` in order. A single differing byte, whether first or last, makes the entry a miss. A longer or shorter length also makes it a miss, even when the name starts the same way.
- R5: Bit 0 of the flags byte set to 1 marks a directory, and a directory entry never matches, even with the right name. Set to 0, it marks a file.
- R6: On a match, `done_o` is high for exactly one cycle, in the cycle after the block's 512th byte is accepted. `data_node_o` then equals the entry's child pointer and holds that value until the next match.
- R7: On a miss with a next pointer of 0, `err_o` is high for exactly one cycle, in the cycle after the 512th byte. No further read request follows.
- R8: On a miss with a nonzero next pointer, the next read request is for the captured base plus that pointer. Nodes are visited in list order, and each node gets one request.
- R9: `start_i` is ignored while `busy_o` is high. The running search keeps its list and its result.
- R10: A byte counts only in a cycle where `byte_vld_i` is high, so idle gaps in the byte stream do not change the result.
- R11: `done_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a search (ignored while busy) |
| root_node_i | input | 32 | Root directory node number |
| part_base_i | input | 32 | Partition base block |
| rd_req_o | output | 1 | One-cycle block read request |
| rd_addr_o | output | 32 | Block address of the request |
| byte_vld_i | input | 1 | Streamed byte valid |
| byte_i | input | 8 | Streamed byte |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle match pulse |
| err_o | output | 1 | One-cycle not-found pulse |
| data_node_o | output | 32 | First data node of the matched file |

## Verification
After a read request, the block's first byte may arrive in the cycle after the request, and the search result is due exactly one cycle after the final node's 512th byte is accepted. The storage model in the bench records the cycle in which it drives each last byte. The monitor takes each result pulse off the expected queue and checks both its kind and handle and that it falls one cycle after that recorded last byte. Every request address is checked against the expected visiting order, and one stream is run with idle gaps to show that only valid bytes count.

// File: rtl/dn_pkg.sv
package dn_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_RECV = 2'd2
  } dn_state_e;

  // byte offsets of the directory node fields within a block
  localparam int OFS_FLAGS = 0;
  localparam int OFS_NEXT  = 1;
  localparam int OFS_CHILD = 5;
  localparam int OFS_NLEN  = 13;
  localparam int OFS_NAME  = 14;
  localparam int PTR_BYTES = 4;
  localparam int FLAG_DIR  = 0;
endpackage

// File: rtl/dn_name_rom.sv
module dn_name_rom #(
  parameter int NAME_LEN = 7,
  parameter logic [NAME_LEN*8-1:0] NAME_STR = "bootimg",
  parameter int IDX_W = 9
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       chr_o
);
  localparam int RIDX_W = (NAME_LEN > 1) ? $clog2(NAME_LEN) : 1;

  logic [7:0] rom [NAME_LEN];

  // first character sits in the most significant byte of the string
  for (genvar g = 0; g < NAME_LEN; g++) begin : g_rom
    assign rom[g] = NAME_STR[(NAME_LEN-1-g)*8 +: 8];
  end

  always_comb begin
    if (idx_i < IDX_W'(NAME_LEN)) chr_o = rom[idx_i[RIDX_W-1:0]];
    else                           chr_o = 8'h00;
  end
endmodule

// File: rtl/dn_node_parser.sv
module dn_node_parser
  import dn_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int NAME_LEN    = 7,
  parameter logic [NAME_LEN*8-1:0] NAME_STR = "bootimg",
  parameter int PTR_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             vld_i,
  input  logic [7:0]       byte_i,
  output logic             last_o,
  output logic             miss_o,
  output logic [PTR_W-1:0] next_o,
  output logic [PTR_W-1:0] child_o
);
  localparam int CNT_W = $clog2(BLOCK_BYTES);
  localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(BLOCK_BYTES - 1);
  localparam logic [CNT_W-1:0] C_FLAGS    = CNT_W'(OFS_FLAGS);
  localparam logic [CNT_W-1:0] C_NLEN     = CNT_W'(OFS_NLEN);
  localparam logic [CNT_W-1:0] C_NAME     = CNT_W'(OFS_NAME);
  localparam logic [CNT_W-1:0] C_NAME_END = CNT_W'(OFS_NAME + NAME_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             miss_q, miss_d;
  logic [PTR_W-1:0] next_q, next_d, child_q, child_d;
  logic [CNT_W-1:0] name_idx;
  logic [7:0]       rom_chr;

  assign name_idx = cnt_q - C_NAME;

  dn_name_rom #(.NAME_LEN(NAME_LEN), .NAME_STR(NAME_STR), .IDX_W(CNT_W)) u_rom (
    .idx_i(name_idx),
    .chr_o(rom_chr)
  );

  // pointer capture, one byte lane per position, least significant first
  for (genvar g = 0; g < PTR_BYTES; g++) begin : g_ptr
    always_comb begin
      next_d[g*8 +: 8]  = next_q[g*8 +: 8];
      child_d[g*8 +: 8] = child_q[g*8 +: 8];
      if (cnt_q == CNT_W'(OFS_NEXT + g))  next_d[g*8 +: 8]  = byte_i;
      if (cnt_q == CNT_W'(OFS_CHILD + g)) child_d[g*8 +: 8] = byte_i;
    end
  end

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    miss_d = miss_q;
    if (cnt_q == C_FLAGS && byte_i[FLAG_DIR]) miss_d = 1'b1;
    if (cnt_q == C_NLEN && byte_i != 8'(NAME_LEN)) miss_d = 1'b1;
    if (cnt_q >= C_NAME && cnt_q < C_NAME_END && byte_i != rom_chr) miss_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      miss_q  <= 1'b0;
      next_q  <= '0;
      child_q <= '0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (vld_i) begin
      cnt_q   <= cnt_d;
      miss_q  <= miss_d;
      next_q  <= next_d;
      child_q <= child_d;
    end
  end

  // the name ends well before the last byte, so miss_q is final here
  assign last_o  = vld_i && (cnt_q == C_LAST);
  assign miss_o  = miss_q;
  assign next_o  = next_q;
  assign child_o = child_q;
endmodule

// File: rtl/dirnode_seeker.sv
module dirnode_seeker
  import dn_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 512,
  parameter int NAME_LEN    = 7,
  parameter logic [NAME_LEN*8-1:0] NAME_STR = "bootimg"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] root_node_i,
  input  logic [ADDR_W-1:0] part_base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] data_node_o
);
  dn_state_e         state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d, base_q, base_d, handle_q, handle_d;
  logic              done_q, done_d, err_q, err_d;
  logic              clear, last, miss;
  logic [ADDR_W-1:0] next_ptr, child_ptr;

  dn_node_parser #(
    .BLOCK_BYTES(BLOCK_BYTES), .NAME_LEN(NAME_LEN),
    .NAME_STR(NAME_STR), .PTR_W(ADDR_W)
  ) u_parse (
    .clk(clk), .rst_n(rst_n), .clear_i(clear),
    .vld_i(byte_vld_i && state_q == S_RECV), .byte_i(byte_i),
    .last_o(last), .miss_o(miss), .next_o(next_ptr), .child_o(child_ptr)
  );

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    base_d   = base_q;
    handle_d = handle_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    clear    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        cur_d   = root_node_i;
        base_d  = part_base_i;
        state_d = S_REQ;
      end
      S_REQ: begin
        clear   = 1'b1;
        state_d = S_RECV;
      end
      S_RECV: if (last) begin
        if (!miss) begin
          done_d   = 1'b1;
          handle_d = child_ptr;
          state_d  = S_IDLE;
        end else if (next_ptr == '0) begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end else begin
          cur_d   = next_ptr;
          state_d = S_REQ;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      base_q   <= '0;
      handle_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      base_q   <= base_d;
      handle_q <= handle_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign rd_req_o    = (state_q == S_REQ);
  assign rd_addr_o   = base_q + cur_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign data_node_o = handle_q;
endmodule

// File: rtl/dirnode_seeker_chk.sv
module dirnode_seeker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] data_node_o
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);
  assert_handle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_node_o) |-> done_o);
  assert_result_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o && !rd_req_o);
endmodule

bind dirnode_seeker dirnode_seeker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_o(rd_req_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .data_node_o(data_node_o)
);

// File: tb/dirnode_seeker_test.sv
module dirnode_seeker_test;
  logic        clk, rst_n, start, byte_vld, rd_req, busy, done, err;
  logic [31:0] root, base, rd_addr, data_node;
  logic [7:0]  bdat;

  dirnode_seeker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .root_node_i(root),
    .part_base_i(base), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .byte_vld_i(byte_vld), .byte_i(bdat), .busy_o(busy), .done_o(done),
    .err_o(err), .data_node_o(data_node)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, last_cyc = 0;
  bit gap_mode = 0, finished = 0;
  logic [31:0] cur_base = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // node image: flags, next, child, name
  logic [7:0]  nflag [int unsigned];
  logic [31:0] nnext [int unsigned];
  logic [31:0] nchild[int unsigned];
  string       nname [int unsigned];

  typedef struct { bit is_err; logic [31:0] handle; string req; } res_t;
  res_t        exp_res[$];
  int unsigned exp_req[$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic mk(int unsigned n, logic [7:0] f, logic [31:0] nx,
                    logic [31:0] ch, string nm);
    nflag[n] = f; nnext[n] = nx; nchild[n] = ch; nname[n] = nm;
  endtask

  function automatic logic [7:0] node_byte(int unsigned n, int i);
    // R3 layout: flags@0, next@1..4 LE, child@5..8 LE, len@13, name@14
    if (i == 0) return nflag[n];
    if (i >= 1 && i <= 4) return nnext[n][(i-1)*8 +: 8];
    if (i >= 5 && i <= 8) return nchild[n][(i-5)*8 +: 8];
    if (i >= 9 && i <= 12) return 8'hA5 ^ 8'(n);
    if (i == 13) return 8'(nname[n].len());
    if (i >= 14 && i < 14 + nname[n].len()) return nname[n][i-14];
    return 8'((i * 7) ^ n);
  endfunction

  // storage reader model
  initial begin
    byte_vld = 0; bdat = 0;
    @(negedge clk);
    forever begin
      if (rd_req) begin
        int unsigned exp_n;
        int unsigned node;
        node = rd_addr - cur_base;
        if (exp_req.size() == 0) begin
          chk(0, "R7/R8 unexpected request", rd_addr, 32'hFFFF_FFFF);
          exp_n = node;
        end else begin
          exp_n = exp_req.pop_front();
          chk(rd_addr == cur_base + exp_n, "R2/R8 request address", rd_addr, cur_base + exp_n);
        end
        @(negedge clk);
        for (int k = 0; k < 512; k++) begin
          if (gap_mode && (k % 5) == 2) begin  // R10 idle gap
            byte_vld = 0; bdat = 8'hEE;
            @(negedge clk);
          end
          byte_vld = 1;
          bdat = nflag.exists(exp_n) ? node_byte(exp_n, k) : 8'h00;
          last_cyc = cyc;
          @(negedge clk);
        end
        byte_vld = 0;
      end else @(negedge clk);
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done || err) begin
        if (exp_res.size() == 0) chk(0, "R9 unexpected result", {30'd0, done, err}, 32'd0);
        else begin
          res_t e;
          e = exp_res.pop_front();
          chk(err == e.is_err && done == !e.is_err, {e.req, " result kind"},
              {30'd0, done, err}, e.is_err ? 32'd1 : 32'd2);
          if (!e.is_err) chk(data_node == e.handle, {e.req, " handle"}, data_node, e.handle);
          chk(cyc == last_cyc + 1, {e.req, " result timing"}, cyc, last_cyc + 1);
        end
      end
    end
  end

  task automatic run(int unsigned r, logic [31:0] b, bit is_err, logic [31:0] h,
                     int unsigned visits[$], string req);
    res_t e;
    e.is_err = is_err; e.handle = h; e.req = req;
    exp_res.push_back(e);
    foreach (visits[i]) exp_req.push_back(visits[i]);
    cur_base = b;
    @(negedge clk);
    root = r; base = b; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, {req, " R2 busy after start"}, busy, 1);
  endtask

  task automatic wait_idle();
    while (busy || exp_res.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_req.size() == 0, "R8 all nodes requested", exp_req.size(), 0);
  endtask

  initial begin
    start = 0; root = 0; base = 0; rst_n = 0;
    mk(10, 8'h00, 11, 32'h0000_0111, "kernel");
    mk(11, 8'h01, 12, 32'h0000_0222, "bootimg");   // directory, R5
    mk(12, 8'h00, 13, 32'h0000_0333, "bootimgs");  // length 8, R4
    mk(13, 8'h02, 0,  32'h1234_5678, "bootimg");   // file (bit0 clear)
    mk(20, 8'h00, 21, 32'h0000_0AAA, "bootimh");   // last char differs
    mk(21, 8'h00, 0,  32'h0000_0BBB, "cootimg");   // first char differs
    mk(30, 8'h00, 31, 32'h0000_0CCC, "bootim");    // length 6
    mk(31, 8'h00, 0,  32'h8000_0001, "bootimg");
    mk(40, 8'h01, 0,  32'h0000_0DDD, "bootimg");   // lone directory
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0 && err == 0, "R1 done/err", {done, err}, 0);
    chk(rd_req == 0, "R1 rd_req", rd_req, 0);
    chk(data_node == 0, "R1 handle", data_node, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 R5 R8 R3: walk to fourth node
    run(10, 0, 0, 32'h1234_5678, '{10, 11, 12, 13}, "R4/R5/R8");
    wait_idle();
    // R6: immediate match at root, handle held afterwards
    run(13, 0, 0, 32'h1234_5678, '{13}, "R6");
    wait_idle();
    chk(data_node == 32'h1234_5678, "R6 handle held", data_node, 32'h1234_5678);
    // R7: end of list reached, first/last char mismatches
    run(20, 0, 1, 0, '{20, 21}, "R7");
    wait_idle();
    chk(data_node == 32'h1234_5678, "R7 handle unchanged", data_node, 32'h1234_5678);
    // R10 with gaps and a nonzero base, R2 address arithmetic
    gap_mode = 1;
    run(30, 1000, 0, 32'h8000_0001, '{30, 31}, "R10");
    wait_idle();
    gap_mode = 0;
    // R9: start while busy ignored
    run(10, 0, 0, 32'h1234_5678, '{10, 11, 12, 13}, "R9");
    repeat (20) @(negedge clk);
    root = 20; base = 77; start = 1;
    @(negedge clk);
    start = 0;
    wait_idle();
    // R5: directory with matching name gives error
    run(40, 5, 1, 0, '{40}, "R5");
    wait_idle();
    chk(busy == 0 && rd_req == 0, "R7 idle after error", {busy, rd_req}, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule